// File: doc/BRIEF.md
# Multichannel SPI Master Controller

This block is a synchronous serial master that shares one serial clock line and one data pair among four peripherals, each with its own active-low chip-select line. Every channel holds its own settings: clock divider, idle polarity, sampling phase, word length, transfer direction and chip-select guard time. Settings are written one channel at a time through a small configuration port. They are copied into the engine when a transfer starts, so changing a channel's settings affects only later transfers.

A transfer starts when `start` is pulsed with a channel number and a transmit word. The block shifts the word out MSB first and collects the receive word. When the chip-select line releases, the block pulses `done` for one cycle and presents the received word right-aligned. One channel, chosen by a parameter, also has a small transmit queue. Words pushed into the queue are sent on that channel, one after another, whenever the engine is idle and no direct start is requested.

Timing base: `clk` runs at twice the serial reference rate. A divider ratio of R gives a serial clock half-period of R `clk` cycles. Ratio code 0 selects ratio 1. Codes 1 to 8 select ratio 2×code. Codes 9 to 15 select ratio 16.

Top module: `spi_multi_master`

## Requirements
- R1: The word length is the configured length-minus-one field plus one, giving 4 to 32 bits; field values below 3 act as 3. A transfer makes exactly 2×length serial clock edges and sends the transmit word MSB first.
- R2: Only the chip-select line of the channel being served is driven low, and only while that transfer is in progress; all lines stay high when idle.
- R3: The serial clock rests at the channel's polarity before the first edge and after the last edge. With phase 0 the data are sampled on the odd (leading) edges; with phase 1 they are sampled on the even (trailing) edges.
- R4: Direction code 0 or 3 is full duplex. Code 1 is transmit-only: the input line is ignored and the received word is zero. Code 2 is receive-only: the output line stays at 0 for the whole transfer.
- R5: The serial clock half-period equals the selected ratio in `clk` cycles, with the code mapping given above, including the clamp to 16.
- R6: For ratios above 1, both of the following intervals are (2×guard+1)×ratio `clk` cycles: from chip-select assertion to the first edge, and from the last edge to chip-select release. The guard field is 2 bits.
- R7: At ratio 1, the phase-dependent interval is 2×(guard+1) `clk` cycles. With phase 1 this is the lead interval; with phase 0 it is the lag interval. The other interval follows R6.
- R8: Words pushed into the queue are sent in order on the queue channel. The queue holds at most four words, and `q_full` is high while it holds four. A push while full is dropped.
- R9: The received word is right-aligned and holds the bits in arrival order; bits above the word length read as zero.
- R10: A start request while the engine is busy is ignored. No second transfer runs and no other chip-select is asserted.
- R11: `done` is a one-cycle pulse in the cycle the chip-select line releases. At that cycle `done_ch` gives the channel served and `rx_word` gives the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the serial reference rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the settings below into channel `cfg_ch` |
| cfg_ch | input | 2 | Channel whose settings are written |
| cfg_pol | input | 1 | Serial clock idle level |
| cfg_pha | input | 1 | Sampling phase |
| cfg_div | input | 4 | Divider ratio code |
| cfg_len | input | 5 | Word length minus one |
| cfg_dir | input | 2 | Direction code |
| cfg_tcs | input | 2 | Chip-select guard field |
| start | input | 1 | Start a transfer on `start_ch` |
| start_ch | input | 2 | Channel for the direct start |
| tx_word | input | 32 | Transmit word for the direct start, right-aligned |
| q_push | input | 1 | Push `q_data` into the queue |
| q_data | input | 32 | Queue word, right-aligned |
| q_full | output | 1 | Queue holds four words |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_ch | output | 2 | Channel of the finished transfer |
| rx_word | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects, one per channel |

## Verification
The bench goes after the guard arithmetic at ratio 1. In that case the lead and lag intervals differ depending on the phase, and a design that applied one formula to both sides would show an interval shorter or longer by one cycle. It also runs 4-bit and 32-bit words and the length clamp. A wrong bit count or shift alignment shows up as a shifted or truncated word, or as high bits leaking into the received word. The receive-only and transmit-only modes are run against a slave that drives nonzero data. This exposes a design that keeps driving the output line or keeps capturing input. A start request while busy and a push into a full queue are also issued, and the bench watches for an extra chip-select or a fifth queued transfer.

// File: rtl/spi_multi_master.sv
module spi_multi_master #(
  parameter int NCH        = 4,
  parameter int CHW        = 2,
  parameter int FIFO_CH    = 0,
  parameter int FIFO_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic            cfg_pol,
  input  logic            cfg_pha,
  input  logic [3:0]      cfg_div,
  input  logic [4:0]      cfg_len,
  input  logic [1:0]      cfg_dir,
  input  logic [1:0]      cfg_tcs,
  input  logic            start,
  input  logic [CHW-1:0]  start_ch,
  input  logic [31:0]     tx_word,
  input  logic            q_push,
  input  logic [31:0]     q_data,
  output logic            q_full,
  output logic            busy,
  output logic            done,
  output logic [CHW-1:0]  done_ch,
  output logic [31:0]     rx_word,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NCH-1:0]  cs_n
);
  localparam int QW = $clog2(FIFO_DEPTH);
  localparam logic [1:0] DIR_TXO = 2'd1;
  localparam logic [1:0] DIR_RXO = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_LAG} st_t;

  function automatic logic [6:0] half_of(input logic [3:0] d);
    if (d == 4'd0) return 7'd1;
    if (d > 4'd8)  return 7'd16;
    return {2'b00, d, 1'b0};
  endfunction

  function automatic logic [6:0] guard_of(input logic [3:0] d, input logic [1:0] t, input logic dep);
    logic [6:0] odd;
    odd = {4'b0000, t, 1'b1};
    if (d == 4'd0 && dep) return {4'b0000, t, 1'b0} + 7'd2;
    return odd * half_of(d);
  endfunction

  logic [NCH-1:0] c_pol, c_pha;
  logic [3:0]     c_div [NCH];
  logic [4:0]     c_len [NCH];
  logic [1:0]     c_dir [NCH];
  logic [1:0]     c_tcs [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_pol <= '0;
      c_pha <= '0;
      for (int i = 0; i < NCH; i++) begin
        c_div[i] <= 4'd1;
        c_len[i] <= 5'd7;
        c_dir[i] <= 2'd0;
        c_tcs[i] <= 2'd0;
      end
    end else if (cfg_we) begin
      c_pol[cfg_ch] <= cfg_pol;
      c_pha[cfg_ch] <= cfg_pha;
      c_div[cfg_ch] <= cfg_div;
      c_len[cfg_ch] <= cfg_len;
      c_dir[cfg_ch] <= cfg_dir;
      c_tcs[cfg_ch] <= cfg_tcs;
    end
  end

  logic [31:0] q_mem [FIFO_DEPTH];
  logic [QW:0] q_wp, q_rp;
  logic        q_empty;
  assign q_empty = (q_wp == q_rp);
  assign q_full  = (q_wp[QW] != q_rp[QW]) && (q_wp[QW-1:0] == q_rp[QW-1:0]);

  st_t            st;
  logic           go_cmd, go_q;
  logic [CHW-1:0] sel_ch;
  logic [31:0]    sel_word;
  logic [4:0]     s_lenm1;
  logic [5:0]     s_len;

  assign busy     = (st != S_IDLE);
  assign go_cmd   = !busy && start;
  assign go_q     = !busy && !start && !q_empty;
  assign sel_ch   = go_cmd ? start_ch : CHW'(FIFO_CH);
  assign sel_word = go_cmd ? tx_word : q_mem[q_rp[QW-1:0]];
  assign s_lenm1  = (c_len[sel_ch] < 5'd3) ? 5'd3 : c_len[sel_ch];
  assign s_len    = {1'b0, s_lenm1} + 6'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wp <= '0;
      q_rp <= '0;
    end else begin
      if (q_push && !q_full) begin
        q_mem[q_wp[QW-1:0]] <= q_data;
        q_wp <= q_wp + 1'b1;
      end
      if (go_q) q_rp <= q_rp + 1'b1;
    end
  end

  logic [CHW-1:0] a_ch;
  logic           a_pha;
  logic [3:0]     a_div;
  logic [1:0]     a_dir;
  logic [5:0]     a_len;
  logic [6:0]     a_lag, cnt, e, eidx, last_e, a_half;
  logic [31:0]    tx_sr, rx_sr;
  logic           fire, smp, shf;

  assign a_half = half_of(a_div);
  assign last_e = {a_len, 1'b0} - 7'd1;
  assign eidx   = (st == S_LEAD) ? 7'd0 : e;
  assign fire   = (st == S_LEAD || st == S_SHIFT) && cnt == 7'd0;
  assign smp    = (eidx[0] == a_pha);
  assign shf    = (eidx[0] != a_pha) && !(a_pha && eidx == 7'd0);
  assign mosi   = busy && (a_dir != DIR_RXO) && tx_sr[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a_ch <= '0; a_pha <= 1'b0; a_div <= 4'd1; a_dir <= 2'd0;
      a_len <= 6'd8; a_lag <= 7'd1; cnt <= '0; e <= '0;
      tx_sr <= '0; rx_sr <= '0;
      sclk <= 1'b0; cs_n <= '1;
      done <= 1'b0; done_ch <= '0; rx_word <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go_cmd || go_q) begin
          a_ch  <= sel_ch;
          a_pha <= c_pha[sel_ch];
          a_div <= c_div[sel_ch];
          a_dir <= c_dir[sel_ch];
          a_len <= s_len;
          a_lag <= guard_of(c_div[sel_ch], c_tcs[sel_ch], !c_pha[sel_ch]);
          cnt   <= guard_of(c_div[sel_ch], c_tcs[sel_ch], c_pha[sel_ch]) - 7'd1;
          e     <= '0;
          tx_sr <= sel_word << (6'd32 - s_len);
          rx_sr <= '0;
          sclk  <= c_pol[sel_ch];
          cs_n  <= ~(NCH'(1) << sel_ch);
          st    <= S_LEAD;
        end
        S_LEAD: if (cnt == 7'd0) begin
          st  <= S_SHIFT;
          cnt <= a_half - 7'd1;
          e   <= 7'd1;
        end else cnt <= cnt - 7'd1;
        S_SHIFT: if (cnt == 7'd0) begin
          if (e == last_e) begin
            st  <= S_LAG;
            cnt <= a_lag - 7'd1;
          end else begin
            e   <= e + 7'd1;
            cnt <= a_half - 7'd1;
          end
        end else cnt <= cnt - 7'd1;
        S_LAG: if (cnt == 7'd0) begin
          cs_n    <= '1;
          done    <= 1'b1;
          done_ch <= a_ch;
          rx_word <= rx_sr;
          st      <= S_IDLE;
        end else cnt <= cnt - 7'd1;
        default: st <= S_IDLE;
      endcase
      if (fire) begin
        sclk <= ~sclk;
        if (smp && a_dir != DIR_TXO) rx_sr <= {rx_sr[30:0], miso};
        if (shf) tx_sr <= {tx_sr[30:0], 1'b0};
      end
    end
  end

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  a_r2_idle_release: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (cs_n == '1));
  a_r11_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n == '1) && $past(cs_n != '1));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r4_rx_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && a_dir == DIR_RXO) |-> !mosi);
  a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(a_ch) && $stable(cs_n));
  a_r6_lead_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LEAD && $past(st) == S_LEAD) |-> $stable(sclk));
endmodule

// File: tb/spi_multi_master_tb.sv
module spi_multi_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_pol = 0, cfg_pha = 0;
  logic [1:0] cfg_ch = 0, cfg_dir = 0, cfg_tcs = 0, start_ch = 0, done_ch;
  logic [3:0] cfg_div = 0;
  logic [4:0] cfg_len = 0;
  logic start = 0, q_push = 0, q_full, busy, done, sclk, mosi, miso = 0;
  logic [31:0] tx_word = 0, q_data = 0, rx_word;
  logic [3:0] cs_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  spi_multi_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_pol(cfg_pol),
    .cfg_pha(cfg_pha), .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_dir(cfg_dir),
    .cfg_tcs(cfg_tcs), .start(start), .start_ch(start_ch), .tx_word(tx_word),
    .q_push(q_push), .q_data(q_data), .q_full(q_full), .busy(busy), .done(done),
    .done_ch(done_ch), .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] o_mosi, o_rx;
  logic [1:0]  o_dch;
  logic        o_done, o_polok;
  int o_lead, o_lag, o_half, o_edges, o_mosi_hi, o_other;

  task automatic set_cfg(input int ch, input int pol, input int pha, input int dv,
                         input int lenm1, input int dir, input int tcs);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_pol = pol[0]; cfg_pha = pha[0]; cfg_div = 4'(dv);
    cfg_len = 5'(lenm1); cfg_dir = 2'(dir); cfg_tcs = 2'(tcs);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic go(input int ch, input logic [31:0] w);
    @(negedge clk);
    start = 1; start_ch = 2'(ch); tx_word = w;
    @(negedge clk);
    start = 0;
  endtask

  task automatic observe(input int ch, input int pol, input int pha, input int len, input logic [31:0] slave);
    int cyc, nedge, nsamp, last, waitc;
    logic prev;
    o_mosi = 0; o_edges = 0; o_mosi_hi = 0; o_other = 0; o_done = 0; o_rx = 0; o_dch = 0;
    o_lead = -1; o_lag = -1; o_half = -1; o_polok = 1;
    waitc = 0;
    while (cs_n[ch] !== 1'b0 && waitc < 3000) begin @(negedge clk); waitc++; end
    if (waitc >= 3000) return;
    if (sclk !== pol[0]) o_polok = 0;
    prev = sclk; cyc = 0; nedge = 0; nsamp = 0; last = 0;
    miso = slave[len-1];
    while (cyc < 4000) begin
      @(negedge clk); cyc++;
      if (sclk !== prev) begin
        nedge++;
        if (nedge == 1) o_lead = cyc;
        if (nedge == 2) o_half = cyc - last;
        last = cyc;
        if (((nedge % 2) == 1) == (pha == 0)) begin
          o_mosi = {o_mosi[30:0], mosi};
          nsamp++;
        end
        prev = sclk;
      end
      miso = (nsamp < len) ? slave[len-1-nsamp] : 1'b0;
      if (mosi === 1'b1) o_mosi_hi++;
      for (int k = 0; k < 4; k++) if (k != ch && cs_n[k] !== 1'b1) o_other++;
      if (cs_n[ch] === 1'b1) begin
        o_lag = cyc - last; o_done = done; o_dch = done_ch; o_rx = rx_word;
        if (sclk !== pol[0]) o_polok = 0;
        break;
      end
    end
    o_edges = nedge;
  endtask

  function automatic int guard_exp(input int ratio, input int tcs, input bit dep);
    if (ratio == 1 && dep) return 2 * (tcs + 1);
    return (2 * tcs + 1) * ratio;
  endfunction

  function automatic logic [31:0] mask_of(input int len);
    return (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  task automatic test_xfer(input string name, input int ch, input int pol, input int pha,
                           input int dv, input int ratio, input int lenm1, input int dir,
                           input int tcs, input logic [31:0] w, input logic [31:0] slave);
    int len;
    len = (lenm1 < 3) ? 4 : lenm1 + 1;
    set_cfg(ch, pol, pha, dv, lenm1, dir, tcs);
    go(ch, w);
    observe(ch, pol, pha, len, slave);
    chk("R1", {name, " edge count"}, o_edges, 2 * len);
    if (dir != 2) chk("R1", {name, " mosi word"}, o_mosi, w & mask_of(len));
    else chk("R4", {name, " rx-only mosi high cycles"}, o_mosi_hi, 0);
    chk("R3", {name, " clock rests at polarity"}, o_polok, 1);
    chk("R5", {name, " half period"}, o_half, ratio);
    chk((ratio == 1 && pha == 1) ? "R7" : "R6", {name, " lead"}, o_lead, guard_exp(ratio, tcs, pha == 1));
    chk((ratio == 1 && pha == 0) ? "R7" : "R6", {name, " lag"}, o_lag, guard_exp(ratio, tcs, pha == 0));
    chk("R11", {name, " done at release"}, o_done, 1);
    chk("R11", {name, " done channel"}, o_dch, ch);
    chk((dir == 1) ? "R4" : "R9", {name, " rx word"}, o_rx, (dir == 1) ? 0 : (slave & mask_of(len)));
    chk("R2", {name, " other selects"}, o_other, 0);
    @(negedge clk);
    chk("R11", {name, " done one cycle"}, done, 0);
  endtask

  task automatic wait_done(output int ndone, output int cs3_low, output int dch);
    ndone = 0; cs3_low = 0; dch = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cs_n[3] === 1'b0) cs3_low++;
      if (done === 1'b1) begin ndone++; dch = int'(done_ch); end
      if (ndone > 0 && !busy) break;
    end
  endtask

  task automatic test_reset();
    chk("R2", "reset selects", cs_n, 4'hF);
    chk("R2", "reset busy", busy, 0);
    chk("R3", "reset sclk", sclk, 0);
    chk("R4", "reset mosi", mosi, 0);
    chk("R11", "reset done", done, 0);
    chk("R8", "reset queue full", q_full, 0);
  endtask

  task automatic test_busy_start();
    int nd, c3, dch;
    set_cfg(2, 0, 1, 3, 31, 0, 1);
    go(2, 32'h1357_9BDF);
    @(negedge clk);
    start = 1; start_ch = 2'd3; tx_word = 32'hFFFF_FFFF;
    @(negedge clk);
    start = 0;
    wait_done(nd, c3, dch);
    chk("R10", "dones for busy start", nd, 1);
    chk("R10", "ignored channel select", c3, 0);
    chk("R10", "served channel", dch, 2);
    repeat (40) @(negedge clk);
    chk("R10", "no late transfer", {busy, cs_n}, 5'h0F);
  endtask

  task automatic test_queue();
    int nd, c3, dch;
    logic [31:0] wq [5];
    wq[0] = 32'h11; wq[1] = 32'h82; wq[2] = 32'hC3; wq[3] = 32'h5A; wq[4] = 32'hEE;
    set_cfg(0, 0, 0, 1, 7, 0, 0);
    set_cfg(2, 0, 1, 3, 31, 0, 1);
    go(2, 32'h0F0F_0F0F);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      q_push = 1; q_data = wq[i];
    end
    @(negedge clk);
    q_push = 0;
    chk("R8", "queue full after four", q_full, 1);
    wait_done(nd, c3, dch);
    for (int i = 0; i < 4; i++) begin
      observe(0, 0, 0, 8, 32'hA0 + 32'(i));
      chk("R8", $sformatf("queue word %0d", i), o_mosi, wq[i]);
      chk("R8", $sformatf("queue channel %0d", i), o_dch, 0);
      chk("R9", $sformatf("queue rx %0d", i), o_rx, 32'hA0 + 32'(i));
    end
    repeat (40) @(negedge clk);
    chk("R8", "dropped fifth push", {busy, cs_n}, 5'h0F);
    chk("R8", "queue drained", q_full, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_xfer("A", 0, 0, 0, 1, 2, 7, 0, 0, 32'hA5, 32'h3C);
    test_xfer("B", 1, 1, 1, 0, 1, 3, 0, 2, 32'h9, 32'hFFFF_FFF6);
    test_xfer("C", 2, 0, 1, 3, 6, 31, 0, 1, 32'hDEAD_BEEF, 32'h1234_5678);
    test_xfer("D", 3, 1, 0, 0, 1, 11, 1, 3, 32'hABC, 32'hFFF);
    test_xfer("E", 1, 0, 0, 2, 4, 15, 2, 0, 32'hFFFF, 32'hBEEF);
    test_xfer("F", 2, 0, 0, 9, 16, 1, 0, 0, 32'hB, 32'h6);
    test_busy_start();
    test_queue();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule